// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 14-bit virtual address into a 14-bit physical address after a translation lookup has missed. It walks a two-level table held in memory. A page directory of sixteen 4-byte entries sits at a physical address held in a base register, which is loaded through a one-cycle configuration write. The upper half of the 8-bit virtual page number selects a directory entry. That entry names the frame holding one page of page-table entries, and the lower half of the page number selects the entry inside that page. The 6-bit byte offset passes through unchanged, so pages are 64 bytes.

A walk begins when a request is accepted in the idle state. The walker then issues at most two reads on a single-outstanding memory port. Each read has a request phase, which stays asserted until the memory acknowledges it, and a response phase of any length. The directory read comes first. If the directory entry is invalid, the walk ends at once with a directory fault. If it is valid, the table read follows. The result is shown for one cycle: a physical address, or a fault code that tells the two fault kinds apart.

The controller has six states: `ST_IDLE`, `ST_DIR_REQ`, `ST_DIR_WAIT`, `ST_TBL_REQ`, `ST_TBL_WAIT` and `ST_DONE`. Its transitions are:
- `ST_IDLE` to `ST_DIR_REQ` when a request is accepted.
- `ST_DIR_REQ` to `ST_DIR_WAIT` on acknowledge.
- `ST_DIR_WAIT` to `ST_TBL_REQ` on a response holding a valid entry.
- `ST_DIR_WAIT` to `ST_DONE` on a response holding an invalid entry.
- `ST_TBL_REQ` to `ST_TBL_WAIT` on acknowledge.
- `ST_TBL_WAIT` to `ST_DONE` on a response.
- `ST_DONE` to `ST_IDLE` always.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and after it is released, the walker is idle: `req_ready` is 1, and `mem_rd_valid` and `done_valid` are 0. After reset the base register holds 0.
- R2: The cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), the walker presents its first read at address base + 4 × vaddr[13:10]. The result is taken modulo 2^14.
- R3: A read request stays asserted, with an unchanged address, in every cycle until the cycle in which `mem_rd_ack` is 1.
- R4: If the directory entry has bit 0 equal to 0, the walk makes no second read. It finishes with `done_fault` = 1 and `done_paddr` = 0.
- R5: If the directory entry has bit 0 equal to 1, the cycle after its response the walker presents a second read at address (entry[15:8] << 6) + 4 × vaddr[9:6].
- R6: If the page-table entry has bit 0 equal to 1, the walk finishes after exactly two reads, with `done_fault` = 0 and `done_paddr` = {entry[15:8], vaddr[5:0]}. Entry bits other than 0 and 15:8 have no effect.
- R7: If the page-table entry has bit 0 equal to 0, the walk finishes with `done_fault` = 2 and `done_paddr` = 0.
- R8: `done_valid` is high for exactly one cycle, the cycle after the last response. The walker is idle again the cycle after that. `req_ready` is 0 for the whole walk, and requests raised during a walk are ignored.
- R9: Acknowledge and response may each take any number of cycles. While a response is outstanding, the walker neither finishes nor issues a read.
- R10: A configuration write loads `cfg_base` into the base register at the clock edge. Every walk accepted after that edge uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the directory base register |
| cfg_base | input | 14 | New directory base address |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, so a request is accepted |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 14 | Memory read byte address |
| mem_rd_ack | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data (a table entry) |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 14 | Physical address, 0 on fault |
| done_fault | output | 2 | 0 none, 1 invalid directory entry, 2 invalid table entry |

## Verification
A state register that is wrong or stuck shows up at the ports within one cycle of the edge where it goes wrong. A missing transition holds `mem_rd_valid` or `req_ready` at the wrong level on the next cycle. A spurious transition raises `done_valid` early or issues a third read. A wrong captured field, base or frame number shows up one cycle after acceptance or after the directory response, as a wrong `mem_rd_addr`. A wrong table field shows up as a wrong `done_paddr` or `done_fault` in the result cycle. The bench predicts every output level cycle by cycle, from its own memory image and its own acknowledge and response timing.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_PTE  = 2'd2
    } walk_fault_t;

endpackage

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_ack,
    input  logic        rsp_valid,
    input  logic        entry_valid,
    output walk_state_t state
);

    walk_state_t next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:     if (start)     next_state = ST_DIR_REQ;
            ST_DIR_REQ:  if (rd_ack)    next_state = ST_DIR_WAIT;
            ST_DIR_WAIT: if (rsp_valid) next_state = entry_valid ? ST_TBL_REQ : ST_DONE;
            ST_TBL_REQ:  if (rd_ack)    next_state = ST_TBL_WAIT;
            ST_TBL_WAIT: if (rsp_valid) next_state = ST_DONE;
            ST_DONE:                    next_state = ST_IDLE;
            default:                    next_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pt_walker_entry.sv
module pt_walker_entry #(
    parameter int DATA_W    = 32,
    parameter int PFN_W     = 8,
    parameter int PFN_LSB   = 8,
    parameter int VALID_BIT = 0
) (
    input  logic [DATA_W-1:0] data,
    output logic              valid,
    output logic [PFN_W-1:0]  pfn
);

    logic unused_data_bits;

    assign valid            = data[VALID_BIT];
    assign pfn              = data[PFN_LSB +: PFN_W];
    assign unused_data_bits = ^data;

endmodule

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
    parameter int VA_W        = 14,
    parameter int PA_W        = 14,
    parameter int OFF_W       = 6,
    parameter int DIR_IDX_W   = 4,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-1:0]       base,
    input  logic [VA_W-1:0]       vaddr,
    input  logic [PA_W-OFF_W-1:0] dir_pfn,
    output logic [PA_W-1:0]       dir_addr,
    output logic [PA_W-1:0]       tbl_addr
);

    localparam int VPN_W       = VA_W - OFF_W;
    localparam int TBL_IDX_W   = VPN_W - DIR_IDX_W;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [TBL_IDX_W-1:0] tbl_idx;

    assign dir_idx  = vaddr[VA_W-1 -: DIR_IDX_W];
    assign tbl_idx  = vaddr[OFF_W +: TBL_IDX_W];

    assign dir_addr = base + (PA_W'(dir_idx) << ENTRY_SHIFT);
    assign tbl_addr = (PA_W'(dir_pfn) << OFF_W) + (PA_W'(tbl_idx) << ENTRY_SHIFT);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W        = 14,
    parameter int PA_W        = 14,
    parameter int OFF_W       = 6,
    parameter int DIR_IDX_W   = 4,
    parameter int ENTRY_BYTES = 4,
    parameter int DATA_W      = 32,
    parameter int PFN_LSB     = 8,
    parameter int VALID_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    output logic              mem_rd_valid,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_paddr,
    output logic [1:0]        done_fault
);

    localparam int PFN_W = PA_W - OFF_W;

    walk_state_t       state;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   walk_base_q;
    logic [VA_W-1:0]   vaddr_q;
    logic [PFN_W-1:0]  dir_pfn_q;
    logic [PA_W-1:0]   res_paddr_q;
    walk_fault_t       res_fault_q;
    logic              ent_valid;
    logic [PFN_W-1:0]  ent_pfn;
    logic [PA_W-1:0]   dir_addr;
    logic [PA_W-1:0]   tbl_addr;
    logic              accept;

    assign accept = req_valid && (state == ST_IDLE);

    pt_walker_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .rd_ack      (mem_rd_ack),
        .rsp_valid   (mem_rsp_valid),
        .entry_valid (ent_valid),
        .state       (state)
    );

    pt_walker_entry #(
        .DATA_W    (DATA_W),
        .PFN_W     (PFN_W),
        .PFN_LSB   (PFN_LSB),
        .VALID_BIT (VALID_BIT)
    ) i_entry (
        .data  (mem_rsp_data),
        .valid (ent_valid),
        .pfn   (ent_pfn)
    );

    pt_walker_addr #(
        .VA_W        (VA_W),
        .PA_W        (PA_W),
        .OFF_W       (OFF_W),
        .DIR_IDX_W   (DIR_IDX_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) i_addr (
        .base     (walk_base_q),
        .vaddr    (vaddr_q),
        .dir_pfn  (dir_pfn_q),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr)
    );

    // Configuration register: the directory base.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      base_q <= '0;
        else if (cfg_we) base_q <= cfg_base;
    end

    // Walk datapath: captured request, directory frame and result.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_base_q <= '0;
            vaddr_q     <= '0;
            dir_pfn_q   <= '0;
            res_paddr_q <= '0;
            res_fault_q <= FLT_NONE;
        end else begin
            if (accept) begin
                walk_base_q <= base_q;
                vaddr_q     <= req_vaddr;
            end
            if (state == ST_DIR_WAIT && mem_rsp_valid) begin
                dir_pfn_q <= ent_pfn;
                if (!ent_valid) begin
                    res_fault_q <= FLT_DIR;
                    res_paddr_q <= '0;
                end
            end
            if (state == ST_TBL_WAIT && mem_rsp_valid) begin
                if (ent_valid) begin
                    res_fault_q <= FLT_NONE;
                    res_paddr_q <= {ent_pfn, vaddr_q[OFF_W-1:0]};
                end else begin
                    res_fault_q <= FLT_PTE;
                    res_paddr_q <= '0;
                end
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        mem_rd_addr  = dir_addr;
        done_valid   = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_DIR_REQ: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = dir_addr;
            end
            ST_TBL_REQ: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = tbl_addr;
            end
            ST_DIR_WAIT, ST_TBL_WAIT: ;
            ST_DONE:     done_valid = 1'b1;
            default:     ;
        endcase
    end

    assign done_paddr = res_paddr_q;
    assign done_fault = res_fault_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int PA_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_rd_valid,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rd_ack,
    input logic            mem_rsp_valid,
    input logic            done_valid,
    input logic [PA_W-1:0] done_paddr,
    input logic [1:0]      done_fault
);

    logic [1:0] reads_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        reads_q <= '0;
        else if (req_valid && req_ready)   reads_q <= '0;
        else if (mem_rd_valid && mem_rd_ack && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
    end

    assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_valid);

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_dir_fault_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 2'd1) |-> (reads_q == 2'd1 && done_paddr == '0));

    assert_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault != 2'd1) |-> (reads_q == 2'd2));

    assert_pte_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 2'd2) |-> (done_paddr == '0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !done_valid));

    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !mem_rd_valid && !done_valid && !mem_rsp_valid)
            |=> (!done_valid && !mem_rd_valid && !req_ready));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) i_pt_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_ack    (mem_rd_ack),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid),
    .done_paddr    (done_paddr),
    .done_fault    (done_fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_base = '0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_rd_valid;
    logic [13:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [13:0] done_paddr;
    logic [1:0]  done_fault;

    pt_walker i_pt_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_base      (cfg_base),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_ack    (mem_rd_ack),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done_valid    (done_valid),
        .done_paddr    (done_paddr),
        .done_fault    (done_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:4095];

    // Reference model state
    int  exp_q[$];
    bit  busy, rd_active, done_now, done_prev;
    bit  rsp_pending, ack_drv, rsp_drv, p_rd_wait;
    int  ack_cnt, rsp_cnt, ack_lat, rsp_lat;
    int  rsp_addr, p_rd_addr;
    int  exp_fault, exp_paddr, base_m;
    bit  p_req_valid, p_req_ready, p_cfg_we;
    int  p_cfg_base, p_vaddr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk_entry(input bit v, input logic [7:0] pfn);
        return {16'hA5C3, pfn, 7'b1010110, v};
    endfunction

    task automatic model_accept(input int va);
        int dir_a, tbl_a;
        logic [31:0] d, t;
        exp_q.delete();
        dir_a = (base_m + ((va >> 10) & 15) * 4) & 16'h3FFF;
        d = mem[dir_a >> 2];
        exp_q.push_back(dir_a);
        if (!d[0]) begin
            exp_fault = 1; exp_paddr = 0;
        end else begin
            tbl_a = ((int'(d[15:8]) << 6) + ((va >> 6) & 15) * 4) & 16'h3FFF;
            t = mem[tbl_a >> 2];
            exp_q.push_back(tbl_a);
            if (t[0]) begin exp_fault = 0; exp_paddr = (int'(t[15:8]) << 6) | (va & 63); end
            else      begin exp_fault = 2; exp_paddr = 0; end
        end
    endtask

    // Cycle-by-cycle model, checker and memory responder
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            busy = 0; rd_active = 0; done_now = 0; done_prev = 0;
            rsp_pending = 0; ack_drv = 0; rsp_drv = 0; p_rd_wait = 0;
            ack_cnt = 0; rsp_cnt = 0; base_m = 0;
            mem_rd_ack = 0; mem_rsp_valid = 0;
            chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
            chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", mem_rd_valid, 0);
            chk(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
        end else begin
            done_now = 0;
            if (rsp_drv) begin
                if (exp_q.size() == 0) done_now = 1;
                else rd_active = 1;
            end
            if (ack_drv) begin rsp_pending = 1; rsp_cnt = 0; end
            if (done_prev) busy = 0;
            if (p_req_valid && p_req_ready) begin
                model_accept(p_vaddr);
                busy = 1; rd_active = 1; ack_cnt = 0;
            end
            if (p_cfg_we) base_m = p_cfg_base;

            chk(req_ready == !busy, "R8 req_ready", req_ready, !busy);
            chk(mem_rd_valid == rd_active, "R9 mem_rd_valid", mem_rd_valid, rd_active);
            if (rd_active && mem_rd_valid) begin
                if (exp_q.size() == 0)
                    chk(0, "R4 no extra read", mem_rd_addr, 0);
                else
                    chk(mem_rd_addr == exp_q[0][13:0], "R2 R5 R10 read address", mem_rd_addr, exp_q[0]);
                if (p_rd_wait)
                    chk(mem_rd_addr == p_rd_addr[13:0], "R3 held address", mem_rd_addr, p_rd_addr);
            end
            chk(done_valid == done_now, "R8 R9 done timing", done_valid, done_now);
            if (done_now && done_valid) begin
                chk(done_fault == exp_fault[1:0], "R4 R6 R7 fault", done_fault, exp_fault);
                chk(done_paddr == exp_paddr[13:0], "R6 R7 paddr", done_paddr, exp_paddr);
            end

            ack_drv = 0; rsp_drv = 0;
            mem_rd_ack = 0; mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_0000;
            p_rd_wait = 0;
            if (rsp_pending) begin
                if (rsp_cnt >= rsp_lat) begin
                    mem_rsp_valid = 1; mem_rsp_data = mem[rsp_addr >> 2];
                    rsp_pending = 0; rsp_drv = 1;
                end else rsp_cnt++;
            end else if (rd_active && mem_rd_valid) begin
                if (ack_cnt >= ack_lat) begin
                    mem_rd_ack = 1; rsp_addr = int'(mem_rd_addr);
                    if (exp_q.size() != 0) void'(exp_q.pop_front());
                    ack_cnt = 0; ack_drv = 1; rd_active = 0;
                end else begin
                    ack_cnt++; p_rd_wait = 1; p_rd_addr = int'(mem_rd_addr);
                end
            end
            done_prev = done_now;
        end
        p_req_valid = req_valid; p_req_ready = req_ready; p_vaddr = int'(req_vaddr);
        p_cfg_we = cfg_we; p_cfg_base = int'(cfg_base);
    end

    task automatic set_base(input logic [13:0] b);
        @(posedge clk); #2; cfg_we = 1; cfg_base = b;
        @(posedge clk); #2; cfg_we = 0;
    endtask

    task automatic walk(input logic [7:0] vpn, input logic [5:0] off, input bit inject);
        @(posedge clk); #2; req_valid = 1; req_vaddr = {vpn, off};
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2; req_valid = 0;
        if (inject) begin
            req_valid = 1; req_vaddr = ~req_vaddr;   // R8: ignored while busy
            @(posedge clk); @(posedge clk); #2; req_valid = 0;
        end
        do @(negedge clk); while (!done_valid);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0000_FF00;
        // Directory at 0x0400
        mem[(14'h0400 >> 2) + 0]  = mk_entry(1, 8'h20);
        mem[(14'h0400 >> 2) + 1]  = mk_entry(1, 8'h21);
        mem[(14'h0400 >> 2) + 3]  = mk_entry(0, 8'h22);
        mem[(14'h0400 >> 2) + 15] = mk_entry(1, 8'h30);
        // Table pages
        mem[(14'h0800 >> 2) + 0]  = mk_entry(1, 8'h0A);
        mem[(14'h0800 >> 2) + 1]  = mk_entry(1, 8'h0B);
        mem[(14'h0800 >> 2) + 4]  = mk_entry(0, 8'h0C);
        mem[(14'h0840 >> 2) + 0]  = mk_entry(1, 8'h17);
        mem[(14'h0C00 >> 2) + 14] = mk_entry(1, 8'h04);
        mem[(14'h0C00 >> 2) + 15] = mk_entry(1, 8'h1C);
        // Second directory at 0x0100
        mem[(14'h0100 >> 2) + 0]  = mk_entry(1, 8'h21);
        ack_lat = 0; rsp_lat = 0;

        repeat (3) @(posedge clk);
        #2; rst_n = 1;
        repeat (2) @(posedge clk);

        set_base(14'h0400);                         // R10
        walk(8'h00, 6'h15, 0);                      // R2 R5 R6
        walk(8'h01, 6'h3F, 1);                      // R6 R8
        ack_lat = 3; rsp_lat = 5;
        walk(8'h04, 6'h01, 0);                      // R7 R9
        walk(8'h30, 6'h2A, 1);                      // R4
        ack_lat = 1; rsp_lat = 2;
        walk(8'h10, 6'h00, 0);
        walk(8'hFE, 6'h3F, 0);
        walk(8'hFF, 6'h07, 0);
        ack_lat = 4; rsp_lat = 0;
        walk(8'h25, 6'h11, 0);                      // directory index 2: invalid
        set_base(14'h0100);                         // R10
        ack_lat = 0; rsp_lat = 3;
        walk(8'h00, 6'h09, 0);
        repeat (4) @(posedge clk);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule